// File: doc/BRIEF.md
# Page-Policy DRAM Command Sequencer

This block turns single-word read and write requests into command sequences for a DRAM device with four banks. Each request carries a direction flag, a bank, a row and a column. The block keeps a separate open-row record for every bank. From that record it decides whether the access needs a precharge, an activate, or only a column command. Row and column share one multiplexed address bus. They go out in different cycles: the row with the activate, the column with the read or write.

The page policy is chosen at run time by `open_page_i`, and the block samples it at each column command. With the input low (close-page), the column command carries the auto-precharge flag, so the row closes after the burst. The next access to that bank then needs an activate but no precharge. With the input high (open-page), the row stays open. A later access to the same row issues only a column command. A different row in that bank must first be precharged.

Read data follows a posted additive latency of 2 plus a CAS latency of 3, and each burst has a fixed length of 4. A free-running counter raises a refresh request every 64 cycles. Pending refresh takes priority over new requests. Before refreshing, the block closes every open bank with a precharge-all.

Top module: `dram_page_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_o` is NOP (0), `rd_valid_o` is 0 and `req_ready_o` is 1.
- R2: A request to a closed bank issues ACT (code 1) in the cycle after acceptance, with the row on `cmd_addr_o`. The column command (RD code 2, WR code 3) follows exactly 3 cycles later, with the column on `cmd_addr_o`.
- R3: When `open_page_i` is 0 at the column command, `cmd_auto_pre_o` is 1 and the bank is then treated as closed. The next access to that bank issues ACT without PRE, even for the same row.
- R4: In open-page mode, a request that hits the open row of its bank issues only the column command, one cycle after acceptance, with `cmd_auto_pre_o` at 0.
- R5: A request to a bank whose open row differs from the requested row issues PRE (code 4) to that bank one cycle after acceptance. ACT follows exactly 3 cycles after PRE, and the column command exactly 3 cycles after ACT.
- R6: After every RD, `rd_valid_o` is high for exactly 4 consecutive cycles, starting 5 cycles after the RD. WR never raises it.
- R7: A refresh becomes pending every 64 cycles. It is served before the next request is accepted. REF (code 6) is issued only when no bank is open; if any bank is open, PREA (code 5) is issued first and REF follows 3 cycles later. In an idle stretch, successive REF commands are exactly 64 cycles apart.
- R8: Each bank's open row is kept independently, so accesses to other banks do not disturb a bank's open row.
- R9: Switching `open_page_i` from 1 to 0 closes no row by itself. A later hit on a row left open issues only the column command, and that command carries auto-precharge.
- R10: `req_ready_o` is 0 from acceptance until the request's column command has been issued. No command is issued in a cycle where `req_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| open_page_i | input | 1 | Page policy: 1 keeps rows open, 0 closes with auto-precharge |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_bank_i | input | 2 | Target bank |
| req_row_i | input | 13 | Target row |
| req_col_i | input | 10 | Target column |
| cmd_o | output | 3 | Command: 0 NOP, 1 ACT, 2 RD, 3 WR, 4 PRE, 5 PREA, 6 REF |
| cmd_bank_o | output | 2 | Bank of ACT, RD, WR or PRE |
| cmd_addr_o | output | 13 | Row for ACT, column for RD/WR, zero otherwise |
| cmd_auto_pre_o | output | 1 | Auto-precharge flag on RD/WR |
| rd_valid_o | output | 1 | Read burst data valid |

## Verification
The assertions assume that the requester holds its fields stable while `req_valid_i` is high. They also assume that reads reach the device only through this block, so successive reads are at least one burst apart. The stimulus drives each request's fields and the policy at a falling edge and holds them until the acceptance edge. It never overlaps two requests. It changes the policy only between requests. Refresh is not suppressed: an open-row model in the bench follows every observed precharge, precharge-all and activate, and it predicts each request's command sequence from that state.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5,
    CMD_REF  = 3'd6
  } dram_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_COL,
    ST_RPRE,
    ST_REF
  } seq_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dps_bank_table.sv
module dps_bank_table #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_en_i,
  input  logic              close_en_i,
  input  logic              close_all_i,
  input  logic [BANK_W-1:0] wr_bank_i,
  input  logic [ROW_W-1:0]  wr_row_i,
  input  logic [BANK_W-1:0] lk_bank_i,
  output logic              lk_open_o,
  output logic [ROW_W-1:0]  lk_row_o,
  output logic              any_open_o
);

  logic [NUM_BANKS-1:0] open_q;
  logic [ROW_W-1:0]     row_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (wr_bank_i == BANK_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q[b] <= 1'b0;
        row_q[b]  <= '0;
      end else if (close_all_i || (close_en_i && sel)) begin
        open_q[b] <= 1'b0;
      end else if (open_en_i && sel) begin
        open_q[b] <= 1'b1;
        row_q[b]  <= wr_row_i;
      end
    end
  end

  assign lk_open_o  = open_q[lk_bank_i];
  assign lk_row_o   = row_q[lk_bank_i];
  assign any_open_o = |open_q;

  // R2
  act_to_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_en_i |-> !open_q[wr_bank_i]);

  // R5
  close_open_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_en_i |-> open_q[wr_bank_i]);

endmodule

// File: rtl/dps_refresh_timer.sv
module dps_refresh_timer #(
  parameter int REF_INTERVAL = 64,
  localparam int CNT_W       = $clog2(REF_INTERVAL)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_done_i,
  output logic ref_pend_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             wrap;

  assign wrap = (cnt_q == CNT_W'(REF_INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap)            pend_q <= 1'b1;
      else if (ref_done_i) pend_q <= 1'b0;
    end
  end

  assign ref_pend_o = pend_q;

  // R7
  ref_pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !ref_done_i) |=> pend_q);

endmodule

// File: rtl/dps_read_pipe.sv
module dps_read_pipe #(
  parameter int AL        = 2,
  parameter int CL        = 3,
  parameter int BURST_LEN = 4,
  localparam int RL       = AL + CL,
  localparam int DEPTH    = RL + BURST_LEN - 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_issue_i,
  output logic rd_valid_o
);

  logic [DEPTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[DEPTH-2:0], rd_issue_i};
  end

  // bit k set: read issued k+1 cycles ago
  assign rd_valid_o = |pipe_q[DEPTH-1:RL-1];

  // R6
  rd_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_issue_i |-> (pipe_q[BURST_LEN-2:0] == '0));

endmodule

// File: rtl/dram_page_sequencer.sv
module dram_page_sequencer
  import dps_pkg::*;
#(
  parameter int NUM_BANKS    = 4,
  parameter int ROW_W        = 13,
  parameter int COL_W        = 10,
  parameter int T_RCD        = 3,
  parameter int T_RP         = 3,
  parameter int T_RFC        = 4,
  parameter int AL           = 2,
  parameter int CL           = 3,
  parameter int BURST_LEN    = 4,
  parameter int REF_INTERVAL = 64,
  localparam int BANK_W      = $clog2(NUM_BANKS),
  localparam int ADDR_W      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_page_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              cmd_auto_pre_o,
  output logic              rd_valid_o
);

  localparam int WAIT_MAX = max2(max2(T_RCD, T_RP), max2(T_RFC, BURST_LEN + T_RP));
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int GAP_W    = $clog2(T_RCD + 1) + 1;

  seq_state_e        st_q, st_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic              go;

  logic              req_wr_q;
  logic [BANK_W-1:0] req_bank_q;
  logic [ROW_W-1:0]  req_row_q;
  logic [COL_W-1:0]  req_col_q;

  logic              open_en, close_en, close_all;
  logic              lk_open, any_open;
  logic [ROW_W-1:0]  lk_row;
  logic [BANK_W-1:0] lk_bank;
  logic              ref_pend, ref_done;
  logic              accept;

  dram_cmd_e         cmd;
  logic [ADDR_W-1:0] addr;
  logic              auto_pre;
  logic              bank_cmd;

  assign go          = (wait_q == '0);
  assign req_ready_o = (st_q == ST_IDLE) && go && !ref_pend;
  assign accept      = req_ready_o && req_valid_i;
  assign lk_bank     = (st_q == ST_IDLE) ? req_bank_i : req_bank_q;

  always_comb begin
    st_d      = st_q;
    wait_d    = (wait_q != '0) ? wait_q - 1'b1 : '0;
    cmd       = CMD_NOP;
    addr      = '0;
    auto_pre  = 1'b0;
    bank_cmd  = 1'b0;
    open_en   = 1'b0;
    close_en  = 1'b0;
    close_all = 1'b0;
    ref_done  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (go && ref_pend) begin
          st_d = any_open ? ST_RPRE : ST_REF;
        end else if (accept) begin
          if (lk_open && (lk_row == req_row_i)) st_d = ST_COL;
          else if (lk_open)                     st_d = ST_PRE;
          else                                  st_d = ST_ACT;
        end
      end
      ST_PRE: if (go) begin
        cmd      = CMD_PRE;
        bank_cmd = 1'b1;
        close_en = 1'b1;
        wait_d   = WAIT_W'(T_RP - 1);
        st_d     = ST_ACT;
      end
      ST_ACT: if (go) begin
        cmd                = CMD_ACT;
        bank_cmd           = 1'b1;
        addr[ROW_W-1:0]    = req_row_q;
        open_en            = 1'b1;
        wait_d             = WAIT_W'(T_RCD - 1);
        st_d               = ST_COL;
      end
      ST_COL: if (go) begin
        cmd             = req_wr_q ? CMD_WR : CMD_RD;
        bank_cmd        = 1'b1;
        addr[COL_W-1:0] = req_col_q;
        auto_pre        = !open_page_i;
        close_en        = !open_page_i;
        // auto-precharge runs after the burst, so the bank is busy for tRP more
        wait_d          = open_page_i ? WAIT_W'(BURST_LEN - 1)
                                      : WAIT_W'(BURST_LEN + T_RP - 1);
        st_d            = ST_IDLE;
      end
      ST_RPRE: if (go) begin
        cmd       = CMD_PREA;
        close_all = 1'b1;
        wait_d    = WAIT_W'(T_RP - 1);
        st_d      = ST_REF;
      end
      ST_REF: if (go) begin
        cmd      = CMD_REF;
        ref_done = 1'b1;
        wait_d   = WAIT_W'(T_RFC - 1);
        st_d     = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      wait_q <= '0;
    end else begin
      st_q   <= st_d;
      wait_q <= wait_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_wr_q   <= 1'b0;
      req_bank_q <= '0;
      req_row_q  <= '0;
      req_col_q  <= '0;
    end else if (accept) begin
      req_wr_q   <= req_write_i;
      req_bank_q <= req_bank_i;
      req_row_q  <= req_row_i;
      req_col_q  <= req_col_i;
    end
  end

  dps_bank_table #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W)
  ) u_bank_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .open_en_i   (open_en),
    .close_en_i  (close_en),
    .close_all_i (close_all),
    .wr_bank_i   (req_bank_q),
    .wr_row_i    (req_row_q),
    .lk_bank_i   (lk_bank),
    .lk_open_o   (lk_open),
    .lk_row_o    (lk_row),
    .any_open_o  (any_open)
  );

  dps_refresh_timer #(
    .REF_INTERVAL (REF_INTERVAL)
  ) u_refresh (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_done_i (ref_done),
    .ref_pend_o (ref_pend)
  );

  dps_read_pipe #(
    .AL        (AL),
    .CL        (CL),
    .BURST_LEN (BURST_LEN)
  ) u_read_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_issue_i (cmd == CMD_RD),
    .rd_valid_o (rd_valid_o)
  );

  assign cmd_o          = cmd;
  assign cmd_bank_o     = bank_cmd ? req_bank_q : '0;
  assign cmd_addr_o     = addr;
  assign cmd_auto_pre_o = auto_pre;

  // activate-to-column spacing tracker for the checks below
  logic             act_pend_q;
  logic [GAP_W-1:0] gap_q;
  logic             is_col;

  assign is_col = (cmd_o == CMD_RD) || (cmd_o == CMD_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_pend_q <= 1'b0;
      gap_q      <= '0;
    end else if (cmd_o == CMD_ACT) begin
      act_pend_q <= 1'b1;
      gap_q      <= '0;
    end else begin
      if (is_col) act_pend_q <= 1'b0;
      if (gap_q != '1) gap_q <= gap_q + 1'b1;
    end
  end

  // R2
  rcd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_col && act_pend_q) |-> (gap_q >= GAP_W'(T_RCD - 1)));

  // R7
  ref_all_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REF) |-> !any_open);

  // R10
  ready_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (cmd_o == CMD_NOP));

endmodule

// File: tb/dram_page_sequencer_bench.sv
module dram_page_sequencer_bench;
  import dps_pkg::*;

  localparam int T_RCD = 3;
  localparam int T_RP  = 3;

  typedef struct packed {
    logic        wr;
    logic [1:0]  bank;
    logic [12:0] row;
    logic [9:0]  col;
    logic        open;
    logic        xbank;
  } vec_t;

  // wr, bank, row, col, open-page, cross-bank hit (R8)
  localparam vec_t VECS [12] = '{
    '{1'b0, 2'd0, 13'd10,   10'd4,    1'b1, 1'b0},
    '{1'b0, 2'd0, 13'd10,   10'd8,    1'b1, 1'b0},
    '{1'b1, 2'd1, 13'd20,   10'd1,    1'b1, 1'b0},
    '{1'b0, 2'd0, 13'd10,   10'd12,   1'b1, 1'b1},
    '{1'b1, 2'd0, 13'd11,   10'd3,    1'b1, 1'b0},
    '{1'b0, 2'd1, 13'd20,   10'd5,    1'b0, 1'b0},
    '{1'b0, 2'd1, 13'd20,   10'd6,    1'b0, 1'b0},
    '{1'b1, 2'd2, 13'd7,    10'd0,    1'b0, 1'b0},
    '{1'b0, 2'd3, 13'd8191, 10'd1023, 1'b1, 1'b0},
    '{1'b0, 2'd3, 13'd0,    10'd0,    1'b1, 1'b0},
    '{1'b1, 2'd3, 13'd0,    10'd9,    1'b1, 1'b0},
    '{1'b0, 2'd2, 13'd7,    10'd2,    1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        open_page = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic [2:0]  cmd;
  logic [1:0]  cmd_bank;
  logic [12:0] cmd_addr;
  logic        cmd_ap;
  logic        rd_valid;

  always #4 clk = ~clk;

  dram_page_sequencer u_dram_page_sequencer (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .open_page_i    (open_page),
    .req_valid_i    (req_valid),
    .req_ready_o    (req_ready),
    .req_write_i    (req_write),
    .req_bank_i     (req_bank),
    .req_row_i      (req_row),
    .req_col_i      (req_col),
    .cmd_o          (cmd),
    .cmd_bank_o     (cmd_bank),
    .cmd_addr_o     (cmd_addr),
    .cmd_auto_pre_o (cmd_ap),
    .rd_valid_o     (rd_valid)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // command log and open-row model, updated from observed commands
  int        cyc = 0;
  int        n_log = 0;
  int        lcmd [1024];
  int        lcyc [1024];
  int        lbank [1024];
  int        laddr [1024];
  int        lap [1024];
  int        ref_cyc [256];
  int        n_ref = 0;
  int        n_prea = 0;
  bit        m_open [4];
  int        m_row [4];
  logic [15:0] sched = '0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (sched[0] || rd_valid) chk(rd_valid === sched[0], "R6", "read valid", int'(rd_valid), int'(sched[0]));
    sched = sched >> 1;
    if (cmd == CMD_RD) sched = sched | 16'h00F0;
    if (cmd != CMD_NOP && n_log < 1024) begin
      lcmd[n_log]  = int'(cmd);
      lcyc[n_log]  = cyc;
      lbank[n_log] = int'(cmd_bank);
      laddr[n_log] = int'(cmd_addr);
      lap[n_log]   = int'(cmd_ap);
      n_log++;
      case (cmd)
        CMD_ACT: begin m_open[cmd_bank] = 1'b1; m_row[cmd_bank] = int'(cmd_addr); end
        CMD_PRE: m_open[cmd_bank] = 1'b0;
        CMD_PREA: begin
          n_prea++;
          for (int b = 0; b < 4; b++) m_open[b] = 1'b0;
        end
        CMD_REF: begin
          chk(!(m_open[0] || m_open[1] || m_open[2] || m_open[3]), "R7",
              "refresh with open bank", 1, 0);
          if (n_ref < 256) ref_cyc[n_ref] = cyc;
          n_ref++;
        end
        CMD_RD, CMD_WR: if (cmd_ap) m_open[cmd_bank] = 1'b0;
        default: ;
      endcase
    end
  end

  task automatic do_req(input vec_t v);
    bit    hit, miss, rdy_bad;
    int    start, acc, k, t, guard, ncmd;
    string tag;
    @(negedge clk); #1;
    req_write = v.wr; req_bank = v.bank; req_row = v.row; req_col = v.col;
    open_page = v.open; req_valid = 1'b1;
    while (!req_ready) begin @(negedge clk); #1; end
    hit   = m_open[v.bank] && (m_row[v.bank] == int'(v.row));
    miss  = m_open[v.bank] && !hit;
    start = n_log;
    acc   = cyc;
    tag   = hit ? (v.xbank ? "R8" : (v.open ? "R4" : "R9")) : (miss ? "R5" : "R2");
    @(negedge clk); #1;
    req_valid = 1'b0;
    rdy_bad = 1'b0;
    guard = 0;
    while (!(n_log > start && (lcmd[n_log-1] == CMD_RD || lcmd[n_log-1] == CMD_WR)) && guard < 40) begin
      if (req_ready) rdy_bad = 1'b1;
      @(negedge clk); #1;
      guard++;
    end
    chk(!rdy_bad && !req_ready, "R10", "ready during request", int'(rdy_bad), 0);
    ncmd = hit ? 1 : (miss ? 3 : 2);
    chk(n_log - start == ncmd, tag, "command count", n_log - start, ncmd);
    if (n_log - start == ncmd) begin
      k = start;
      t = acc + 1;
      if (miss) begin
        chk(lcmd[k] == CMD_PRE && lbank[k] == int'(v.bank), "R5", "precharge", lcmd[k], CMD_PRE);
        chk(lcyc[k] == t, "R5", "precharge cycle", lcyc[k], t);
        k++; t += T_RP;
      end
      if (!hit) begin
        chk(lcmd[k] == CMD_ACT && laddr[k] == int'(v.row) && lbank[k] == int'(v.bank),
            tag, "activate row", laddr[k], int'(v.row));
        chk(lcyc[k] == t, tag, "activate cycle", lcyc[k], t);
        k++; t += T_RCD;
      end
      chk(lcmd[k] == (v.wr ? CMD_WR : CMD_RD) && laddr[k] == int'(v.col) && lbank[k] == int'(v.bank),
          tag, "column command", laddr[k], int'(v.col));
      chk(lcyc[k] == t, tag, "column cycle", lcyc[k], t);
      chk(lap[k] == int'(!v.open), v.open ? "R4" : "R3", "auto-precharge flag", lap[k], int'(!v.open));
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int r0;
    for (int b = 0; b < 4; b++) begin m_open[b] = 1'b0; m_row[b] = 0; end
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(cmd == CMD_NOP && !rd_valid, "R1", "outputs in reset", int'(cmd), 0);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready && cmd == CMD_NOP && !rd_valid, "R1", "first cycle after reset",
        int'(req_ready), 1);

    for (int i = 0; i < 12; i++) do_req(VECS[i]);

    // R3 close-page same-row reopen: bank 1 row 20 closed by auto-precharge, ask again
    do_req('{1'b1, 2'd1, 13'd20, 10'd33, 1'b0, 1'b0});

    // R7 idle refresh spacing and precharge-all of open rows
    r0 = n_ref;
    repeat (700) @(negedge clk);
    #1;
    chk(n_ref - r0 >= 10 && n_ref - r0 <= 11, "R7", "refresh count in idle", n_ref - r0, 10);
    chk(n_prea > 0, "R7", "precharge-all before refresh", n_prea, 1);
    if (n_ref >= 3) begin
      chk(ref_cyc[n_ref-1] - ref_cyc[n_ref-2] == 64, "R7", "refresh interval",
          ref_cyc[n_ref-1] - ref_cyc[n_ref-2], 64);
      chk(ref_cyc[n_ref-2] - ref_cyc[n_ref-3] == 64, "R7", "refresh interval",
          ref_cyc[n_ref-2] - ref_cyc[n_ref-3], 64);
    end

    // after refresh every bank is closed: open-page request must activate (R2)
    do_req('{1'b0, 2'd2, 13'd7, 10'd2, 1'b1, 1'b0});
    repeat (12) @(negedge clk);
    finish_run();
  end

endmodule